// File: doc/BRIEF.md
# Dual-Codec Serial Control Writer

This block sends register writes to two audio converter chips over a three-wire control port. The two chips share one clock line and one data line; each chip has its own active-low select. Each transfer is one 16-bit word, most significant bit first: a fixed two-bit device code, a write flag, a five-bit register number and eight data bits. The target samples data on the rising clock edge.

The block keeps a shadow byte for every register of every chip, so it can do read-modify-write updates without reading the converters back. A host issues one of four commands with a start strobe. A plain write goes to one chip. A masked update goes to all chips in turn, and each chip's new value is built from that chip's own shadow byte. A sample-rate update derives the format bits of register 2 from a rate in hertz. A soft-mute update changes bit 7 of register 3. The clock half-period is a parameter counted in system clocks.

Control FSM states: `TP_IDLE` (waiting; decodes `start_i`), `TP_LOAD` (builds the value from the shadow, writes the shadow, launches one frame) and `TP_WAIT` (waits for the frame to end). Its transitions are: IDLE→LOAD on an accepted command; LOAD→WAIT always; WAIT→LOAD when a broadcast has another chip left; WAIT→IDLE after the last frame, which also pulses done. Serializer states: `SH_IDLE`, `SH_LEAD` (select low, clock high), `SH_LOW` (clock low, data driven), `SH_HIGH` (clock high) and `SH_TRAIL` (select held after the last bit). Its transitions are: IDLE→LEAD on launch; LEAD→LOW; LOW→HIGH; HIGH→LOW while bits remain; HIGH→TRAIL after bit 0; TRAIL→IDLE. Each of these phases lasts `HALF` clocks.

Top module: `ccw_ctrl`

## Requirements
- R1: Each frame is 16 bits, sent MSB first. Bits 15:14 are 2'b10, bit 13 is 1, bits 12:8 are the register address and bits 7:0 are the data.
- R2: Every bit is a clock-low phase of `HALF` cycles, with the data line set as the clock falls, followed by a clock-high phase of `HALF` cycles. The data line does not change while the clock is high inside a frame.
- R3: During a frame only the addressed chip's select is low, and never more than one select is low. The select falls `HALF` cycles before the first clock fall and rises `HALF` cycles after the last rising clock edge.
- R4: After reset and whenever the block is not busy, the clock, the data line and both selects are high, and busy, done and err are low.
- R5: A write command (`cmd_i`=0) sends `data_i` to register `addr_i` of chip `chip_i`. It updates only that chip's shadow byte.
- R6: A masked command (`cmd_i`=1) sends one frame to each chip in order 0,1. Each frame carries (shadow & ~`mask_i`) | `data_i` for register `addr_i`, and that value becomes the chip's new shadow.
- R7: A rate command (`cmd_i`=2) is a masked broadcast to register 2 with mask 8'h0F. The value is 8'h0A when `rate_i` > 108000, 8'h05 when `rate_i` > 54000, and 8'h00 otherwise.
- R8: A rate command with `rate_i`=0 sends no frame and raises no busy. Done pulses in the cycle after the strobe.
- R9: A mute command (`cmd_i`=3) is a masked broadcast to register 3 with mask 8'h80. The value is 8'h80 when `data_i[7]` is 1 and 8'h00 otherwise.
- R10: A write command with `chip_i` ≥ 2 pulses err for one cycle in the cycle after the strobe, with no busy, no done and no select activity. Broadcast commands ignore `chip_i`.
- R11: Busy rises in the cycle after an accepted strobe. It stays high until the last select has been released, and falls in the same cycle as a one-cycle done pulse.
- R12: A strobe that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start_i | input | 1 | command strobe |
| cmd_i | input | 2 | 0 write, 1 masked, 2 rate, 3 mute |
| chip_i | input | IDX_W | target chip for a write command |
| addr_i | input | 5 | register address |
| data_i | input | 8 | write data / masked value / mute in bit 7 |
| mask_i | input | 8 | bits replaced by a masked command |
| rate_i | input | RATE_W | sample rate in Hz for a rate command |
| busy_o | output | 1 | command in progress |
| done_o | output | 1 | one-cycle completion pulse |
| err_o | output | 1 | one-cycle rejection pulse |
| spi_clk_o | output | 1 | shared serial clock |
| spi_dat_o | output | 1 | shared serial data |
| spi_cs_n_o | output | NCH | per-chip active-low select |

## Verification
The assertions check the line-level rules on every cycle: at most one select is low, data holds while the clock is high, all lines are high when the block is idle, a select is only low while busy, err never coincides with activity, and busy only falls together with done. Only the bench scenarios can show that frame contents are correct, that the phases have the right lengths, and how values come together through the shadow copies. These include read-modify-write results that differ per chip, the strict edges of the rate thresholds, the rate-zero case that does nothing, and a strobe that is dropped while the block is busy.

// File: rtl/ccw_pkg.sv
package ccw_pkg;
    typedef enum logic [1:0] {
        CMD_WRITE  = 2'd0,
        CMD_MASKED = 2'd1,
        CMD_RATE   = 2'd2,
        CMD_MUTE   = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        SH_IDLE, SH_LEAD, SH_LOW, SH_HIGH, SH_TRAIL
    } sh_state_e;

    typedef enum logic [1:0] {
        TP_IDLE, TP_LOAD, TP_WAIT
    } tp_state_e;

    localparam logic [1:0] DEV_CODE  = 2'b10;
    localparam logic [4:0] RATE_REG  = 5'd2;
    localparam logic [4:0] MUTE_REG  = 5'd3;
    localparam logic [7:0] RATE_MASK = 8'h0F;
    localparam logic [7:0] MUTE_MASK = 8'h80;
    localparam logic [7:0] RATE_HIGH = 8'h0A;
    localparam logic [7:0] RATE_MID  = 8'h05;
endpackage

// File: rtl/ccw_shadow.sv
module ccw_shadow #(
    parameter int NCH = 2,
    parameter int AW  = 5,
    parameter int DW  = 8,
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [SEL_W-1:0] chip_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o
);
    logic [DW-1:0] mem [NCH][DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++)
                for (int a = 0; a < DEPTH; a++)
                    mem[c][a] <= '0;
        end else if (we_i) begin
            mem[chip_i][addr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[chip_i][addr_i];
endmodule

// File: rtl/ccw_shifter.sv
module ccw_shifter
    import ccw_pkg::*;
#(
    parameter int NCH     = 2,
    parameter int HALF    = 4,
    parameter int FRAME_W = 16,
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1,
    localparam int BIT_W = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               sclk_o,
    output logic               sdat_o,
    output logic [NCH-1:0]     cs_n_o,
    output logic               fin_o
);
    sh_state_e          st;
    logic [CNT_W-1:0]   cnt;
    logic [BIT_W-1:0]   bit_q;
    logic [FRAME_W-1:0] word_q;
    logic [SEL_W-1:0]   sel_q;
    logic               sd_q;
    logic               phase_end;

    assign phase_end = (cnt == CNT_W'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= SH_IDLE;
            cnt    <= '0;
            bit_q  <= '0;
            word_q <= '0;
            sel_q  <= '0;
            sd_q   <= 1'b1;
            fin_o  <= 1'b0;
        end else begin
            fin_o <= 1'b0;
            unique case (st)
                SH_IDLE: if (go_i) begin
                    st     <= SH_LEAD;
                    cnt    <= '0;
                    word_q <= frame_i;
                    sel_q  <= sel_i;
                    sd_q   <= 1'b1;
                end
                SH_LEAD: begin
                    cnt <= phase_end ? '0 : cnt + 1'b1;
                    if (phase_end) begin
                        st    <= SH_LOW;
                        bit_q <= BIT_W'(FRAME_W - 1);
                        sd_q  <= word_q[FRAME_W-1];
                    end
                end
                SH_LOW: begin
                    cnt <= phase_end ? '0 : cnt + 1'b1;
                    if (phase_end) st <= SH_HIGH;
                end
                SH_HIGH: begin
                    cnt <= phase_end ? '0 : cnt + 1'b1;
                    if (phase_end) begin
                        if (bit_q == '0) begin
                            st <= SH_TRAIL;
                        end else begin
                            st    <= SH_LOW;
                            bit_q <= bit_q - 1'b1;
                            sd_q  <= word_q[bit_q - 1'b1];
                        end
                    end
                end
                SH_TRAIL: begin
                    cnt <= phase_end ? '0 : cnt + 1'b1;
                    if (phase_end) begin
                        st    <= SH_IDLE;
                        fin_o <= 1'b1;
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

    logic active;
    always_comb begin
        active = (st != SH_IDLE);
        sclk_o = (st != SH_LOW);
        sdat_o = active ? sd_q : 1'b1;
    end

    for (genvar gi = 0; gi < NCH; gi++) begin : g_cs
        assign cs_n_o[gi] = !(active && (sel_q == SEL_W'(gi)));
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o)); // R3

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o) && !(&cs_n_o) && !(&$past(cs_n_o)))
            |-> $stable(sdat_o)); // R2
endmodule

// File: rtl/ccw_ctrl.sv
module ccw_ctrl
    import ccw_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int IDX_W  = 2,
    parameter int HALF   = 4,
    parameter int AW     = 5,
    parameter int DW     = 8,
    parameter int RATE_W = 18,
    parameter int HI_HZ  = 108000,
    parameter int MID_HZ = 54000,
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int FRAME_W = 3 + AW + DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        cmd_i,
    input  logic [IDX_W-1:0]  chip_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW-1:0]     data_i,
    input  logic [DW-1:0]     mask_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              spi_clk_o,
    output logic              spi_dat_o,
    output logic [NCH-1:0]    spi_cs_n_o
);
    function automatic logic [DW-1:0] rate_code(input logic [RATE_W-1:0] r);
        if (r > RATE_W'(HI_HZ))  return DW'(RATE_HIGH);
        if (r > RATE_W'(MID_HZ)) return DW'(RATE_MID);
        return '0;
    endfunction

    tp_state_e        st;
    logic [SEL_W-1:0] k_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    val_q, mask_q;
    logic             bcast_q;
    logic [DW-1:0]    shadow_rd, new_val;
    logic             fin, go;
    cmd_e             cmd;

    assign cmd = cmd_e'(cmd_i);

    ccw_shadow #(.NCH(NCH), .AW(AW), .DW(DW)) u_shadow (
        .clk(clk), .rst_n(rst_n), .we_i(st == TP_LOAD), .chip_i(k_q),
        .addr_i(addr_q), .wdata_i(new_val), .rdata_o(shadow_rd)
    );

    ccw_shifter #(.NCH(NCH), .HALF(HALF), .FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .go_i(go), .sel_i(k_q),
        .frame_i({DEV_CODE, 1'b1, addr_q, new_val}),
        .sclk_o(spi_clk_o), .sdat_o(spi_dat_o), .cs_n_o(spi_cs_n_o), .fin_o(fin)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= TP_IDLE;
            k_q     <= '0;
            addr_q  <= '0;
            val_q   <= '0;
            mask_q  <= '0;
            bcast_q <= 1'b0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            unique case (st)
                TP_IDLE: if (start_i) begin
                    unique case (cmd)
                        CMD_WRITE: begin
                            if (chip_i >= IDX_W'(NCH)) begin
                                err_o <= 1'b1;
                            end else begin
                                st      <= TP_LOAD;
                                k_q     <= SEL_W'(chip_i);
                                addr_q  <= addr_i;
                                val_q   <= data_i;
                                bcast_q <= 1'b0;
                            end
                        end
                        CMD_MASKED: begin
                            st      <= TP_LOAD;
                            k_q     <= '0;
                            addr_q  <= addr_i;
                            val_q   <= data_i;
                            mask_q  <= mask_i;
                            bcast_q <= 1'b1;
                        end
                        CMD_RATE: begin
                            if (rate_i == '0) begin
                                done_o <= 1'b1;
                            end else begin
                                st      <= TP_LOAD;
                                k_q     <= '0;
                                addr_q  <= AW'(RATE_REG);
                                val_q   <= rate_code(rate_i);
                                mask_q  <= DW'(RATE_MASK);
                                bcast_q <= 1'b1;
                            end
                        end
                        CMD_MUTE: begin
                            st      <= TP_LOAD;
                            k_q     <= '0;
                            addr_q  <= AW'(MUTE_REG);
                            val_q   <= data_i[DW-1] ? DW'(MUTE_MASK) : '0;
                            mask_q  <= DW'(MUTE_MASK);
                            bcast_q <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                TP_LOAD: st <= TP_WAIT;
                TP_WAIT: if (fin) begin
                    if (bcast_q && (k_q != SEL_W'(NCH - 1))) begin
                        k_q <= k_q + 1'b1;
                        st  <= TP_LOAD;
                    end else begin
                        st     <= TP_IDLE;
                        done_o <= 1'b1;
                    end
                end
                default: st <= TP_IDLE;
            endcase
        end
    end

    always_comb begin
        busy_o  = (st != TP_IDLE);
        go      = (st == TP_LOAD);
        new_val = bcast_q ? ((shadow_rd & ~mask_q) | val_q) : val_q;
    end

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (spi_clk_o && spi_dat_o && (&spi_cs_n_o))); // R4

    AST_SELECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(&spi_cs_n_o) |-> busy_o); // R11

    AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R11

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && !done_o && (&spi_cs_n_o))); // R10
endmodule

// File: tb/ccw_ctrl_tb.sv
module ccw_ctrl_tb;
    localparam int HALF = 2;
    localparam int NCH  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  cmd_i = '0;
    logic [1:0]  chip_i = '0;
    logic [4:0]  addr_i = '0;
    logic [7:0]  data_i = '0;
    logic [7:0]  mask_i = '0;
    logic [17:0] rate_i = '0;
    logic        busy_o, done_o, err_o, spi_clk_o, spi_dat_o;
    logic [1:0]  spi_cs_n_o;

    always #5 clk = ~clk;

    ccw_ctrl #(.NCH(NCH), .HALF(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
        .chip_i(chip_i), .addr_i(addr_i), .data_i(data_i), .mask_i(mask_i),
        .rate_i(rate_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .spi_clk_o(spi_clk_o), .spi_dat_o(spi_dat_o), .spi_cs_n_o(spi_cs_n_o)
    );

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    logic [7:0] model [NCH][32];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: decodes frames at the port and compares with the queue
    logic [15:0] mw;
    int nbits, lowcnt, leadcnt, cur_chip;
    bit in_frame = 0, tim_bad;
    logic prev_sclk = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!(&spi_cs_n_o)) begin
                if ($countones(~spi_cs_n_o) != 1) begin
                    fails++;
                    $display("FAIL R3 selects actual=%0b expected one low", spi_cs_n_o);
                end
                if (!in_frame) begin
                    in_frame = 1; nbits = 0; lowcnt = 0; leadcnt = 0; tim_bad = 0;
                    cur_chip = spi_cs_n_o[0] ? 1 : 0;
                end
                if (spi_clk_o == 1'b0) lowcnt++;
                else if (prev_sclk == 1'b0) begin
                    if (lowcnt != HALF) tim_bad = 1;
                    lowcnt = 0;
                    mw = {mw[14:0], spi_dat_o};
                    nbits++;
                end
                if (nbits == 0 && spi_clk_o) leadcnt++;
            end else if (in_frame) begin
                int got;
                in_frame = 0;
                got = (cur_chip << 16) | mw;
                if (exp_q.size() == 0) begin
                    chk(0, "R1 unexpected frame", got, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(got == e, "R1/R5/R6 frame", got, e);
                    chk(nbits == 16 && leadcnt == HALF && !tim_bad,
                        "R2/R3 timing", (nbits << 8) | leadcnt, (16 << 8) | HALF);
                end
            end
            prev_sclk = spi_clk_o;
        end
    end

    function automatic int frame_of(int chip, logic [4:0] a, logic [7:0] v);
        return (chip << 16) | {2'b10, 1'b1, a, v};
    endfunction

    task automatic pulse(input logic [1:0] c, input logic [1:0] ch, input logic [4:0] a,
                         input logic [7:0] d, input logic [7:0] m, input logic [17:0] r);
        @(negedge clk);
        cmd_i = c; chip_i = ch; addr_i = a; data_i = d; mask_i = m; rate_i = r;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic bcast_expect(input logic [4:0] a, input logic [7:0] m, input logic [7:0] v);
        for (int c = 0; c < NCH; c++) begin
            model[c][a] = (model[c][a] & ~m) | v;
            exp_q.push_back(frame_of(c, a, model[c][a]));
        end
    endtask

    task automatic finish_cmd(input string req);
        chk(busy_o == 1'b1, "R11 busy after strobe", busy_o, 1);
        while (!done_o) @(negedge clk);
        chk(busy_o == 1'b0, "R11 busy low with done", busy_o, 0);
        @(negedge clk);
        chk(done_o == 1'b0 && (&spi_cs_n_o), {req, " done single pulse"}, done_o, 0);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, {req, " frames delivered"}, exp_q.size(), 0);
    endtask

    task automatic do_write(input int ch, input logic [4:0] a, input logic [7:0] d);
        model[ch][a] = d;
        exp_q.push_back(frame_of(ch, a, d));
        pulse(2'd0, 2'(ch), a, d, 8'h00, '0);
        finish_cmd("R5");
    endtask

    task automatic do_rate(input int r);
        logic [7:0] v;
        v = (r > 108000) ? 8'h0A : (r > 54000) ? 8'h05 : 8'h00;
        bcast_expect(5'd2, 8'h0F, v);
        pulse(2'd2, 2'd0, 5'd0, 8'h00, 8'h00, 18'(r));
        finish_cmd("R7");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++)
            for (int a = 0; a < 32; a++) model[c][a] = 8'h00;
        repeat (3) @(negedge clk);
        chk(spi_clk_o && spi_dat_o && (&spi_cs_n_o), "R4 lines in reset",
            {spi_clk_o, spi_dat_o, spi_cs_n_o}, 4'hF);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !err_o, "R4 flags after reset", {busy_o, done_o, err_o}, 0);
        chk(spi_clk_o && spi_dat_o && (&spi_cs_n_o), "R4 idle lines",
            {spi_clk_o, spi_dat_o, spi_cs_n_o}, 4'hF);

        // R1/R5: plain writes, both chips, boundary data and address
        do_write(0, 5'd5, 8'hA5);
        do_write(1, 5'd2, 8'h30);
        do_write(1, 5'd31, 8'hFF);
        do_write(0, 5'd31, 8'h00);

        // R7: rate thresholds, strict comparisons
        do_rate(96000);
        do_rate(192000);
        do_rate(108000);
        do_rate(54000);
        do_rate(54001);
        do_rate(108001);

        // R8: rate zero does nothing but pulse done
        pulse(2'd2, 2'd0, 5'd0, 8'h00, 8'h00, 18'd0);
        chk(done_o == 1'b1 && busy_o == 1'b0, "R8 rate zero done, no busy",
            {done_o, busy_o}, 2'b10);
        repeat (6) @(negedge clk);
        chk(&spi_cs_n_o && exp_q.size() == 0, "R8 rate zero no frame", spi_cs_n_o, 2'b11);

        // R9: soft mute on then off
        bcast_expect(5'd3, 8'h80, 8'h80);
        pulse(2'd3, 2'd0, 5'd0, 8'h80, 8'h00, '0);
        finish_cmd("R9");
        bcast_expect(5'd3, 8'h80, 8'h00);
        pulse(2'd3, 2'd0, 5'd0, 8'h7F, 8'h00, '0);
        finish_cmd("R9");

        // R6/R10: masked broadcast with out-of-range chip index ignored
        bcast_expect(5'd5, 8'hF0, 8'h03);
        pulse(2'd1, 2'd3, 5'd5, 8'h03, 8'hF0, '0);
        finish_cmd("R6");
        bcast_expect(5'd31, 8'h0F, 8'h0C);
        pulse(2'd1, 2'd2, 5'd31, 8'h0C, 8'h0F, '0);
        finish_cmd("R6");

        // R10: write to a chip that does not exist
        pulse(2'd0, 2'd2, 5'd4, 8'h55, 8'h00, '0);
        chk(err_o == 1'b1 && busy_o == 1'b0 && done_o == 1'b0, "R10 err pulse",
            {err_o, busy_o, done_o}, 3'b100);
        @(negedge clk);
        chk(err_o == 1'b0, "R10 err one cycle", err_o, 0);
        repeat (6) @(negedge clk);
        chk(&spi_cs_n_o && exp_q.size() == 0, "R10 no select activity", spi_cs_n_o, 2'b11);

        // R12: strobe while busy is dropped
        model[1][5'd9] = 8'h3C;
        exp_q.push_back(frame_of(1, 5'd9, 8'h3C));
        pulse(2'd0, 2'd1, 5'd9, 8'h3C, 8'h00, '0);
        repeat (3) @(negedge clk);
        cmd_i = 2'd0; chip_i = 2'd0; addr_i = 5'd10; data_i = 8'hEE; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        repeat (8) @(negedge clk);
        chk(!busy_o && exp_q.size() == 0, "R12 ignored strobe", busy_o, 0);
        // shadow of chip 0 reg 10 must still be zero: masked update reveals it
        bcast_expect(5'd10, 8'h00, 8'h00);
        pulse(2'd1, 2'd0, 5'd10, 8'h00, 8'h00, '0);
        finish_cmd("R12");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule